// File: doc/BRIEF.md
# Pixel Tile Row-to-Column Rotator

This block turns monochrome image data packed as row bytes, with each byte holding eight side-by-side pixels, into column bytes, with each byte holding eight pixels stacked vertically. Some display controllers expect that second packing. The block takes the eight row bytes of one 8x8 tile on a valid/ready input stream. It then returns the eight column bytes of that tile on a valid/ready output stream. The tile is rotated through 90 degrees as a bit matrix; the bytes are not simply copied or reordered.

A tile walker follows where the tile being drained sits in a 128x64 frame. It goes across the 16 tiles of one 8-row band, then moves down through the 8 bands. It labels each output byte with its column index and tile coordinates. When the final column of the final tile has been taken downstream, it raises a one-cycle frame-complete pulse. Upstream logic sends the tiles of a frame in that same order.

Top module: `pix_tile_rotator`

## Requirements
- R1: While reset is held and on the first cycle after it, `in_ready` is 1, `out_valid` is 0, `frame_done` is 0, and both tile coordinates are 0.
- R2: `in_ready` is high exactly while fewer than eight rows of the current tile are held. After the eighth row is accepted, `in_ready` stays low until all eight column bytes have been accepted.
- R3: `out_valid` rises in the cycle after the eighth row handshake. It stays high until the eighth column handshake and is low at all other times.
- R4: Column byte k (k = 0 is the leftmost pixel column) has bit r equal to bit (7-k) of row byte r. Bit 7 of a row byte is its leftmost pixel, and row 0 lands in bit 0. Columns leave in the order k = 0 to 7.
- R5: While `out_valid` is high and `out_ready` is low, `out_data` and `out_col` hold their values into the next cycle.
- R6: Data presented with `in_valid` high while `in_ready` is low is ignored. It has no effect on the current tile or on later tiles.
- R7: `out_col` carries the index k of the column byte on `out_data`. It steps by one on each output handshake.
- R8: `out_tile_x` (0..15) and `out_tile_y` (0..7) give the position of the tile being drained. After each finished tile, x advances. When x wraps from 15 to 0, y advances, and y wraps from 7 to 0.
- R9: `frame_done` is a one-cycle pulse. It is high in the cycle after the last column byte of tile (x=15, y=7) is accepted, and low at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Row byte offered |
| in_ready | output | 1 | Rotator can take a row byte |
| in_data | input | 8 | Row byte, bit 7 = leftmost pixel |
| out_valid | output | 1 | Column byte offered |
| out_ready | input | 1 | Downstream takes the column byte |
| out_data | output | 8 | Column byte, bit 0 = top row |
| out_col | output | 3 | Column index of `out_data` within the tile |
| out_tile_x | output | 4 | Tile column in the frame |
| out_tile_y | output | 3 | Tile band in the frame |
| frame_done | output | 1 | Pulse after the last byte of the frame |

## Verification
A wrong row write index or a wrong column select in the rotation network shows up on `out_data` in the first drain that follows. The stimulus includes single-pixel and diagonal tiles, so each misrouted bit affects one specific byte. A phase counter that is off by one leaves `in_ready` and `out_valid` wrong by a cycle, and the bench compares both every cycle against its own handshake count. A tile walker that slips shows up on the coordinate outputs of the next tile, and the `frame_done` pulse would move away from the one cycle in which it is expected.

// File: rtl/pix_tile_pkg.sv
package pix_tile_pkg;
   typedef enum logic {
      PH_FILL  = 1'b0,
      PH_DRAIN = 1'b1
   } phase_t;
endpackage

// File: rtl/tile_phase_ctrl.sv
module tile_phase_ctrl
   import pix_tile_pkg::*;
#(
   parameter int N = 8,
   localparam int IW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          out_ready,
   output logic          in_ready,
   output logic          out_valid,
   output logic          wr_fire,
   output logic          tile_end,
   output logic [IW-1:0] idx
);
   localparam logic [IW-1:0] IDX_LAST = IW'(N - 1);

   phase_t        phase_q;
   logic [IW-1:0] idx_q;
   logic          rd_fire;

   assign in_ready  = (phase_q == PH_FILL);
   assign out_valid = (phase_q == PH_DRAIN);
   assign wr_fire   = in_ready & in_valid;
   assign rd_fire   = out_valid & out_ready;
   assign tile_end  = rd_fire && (idx_q == IDX_LAST);
   assign idx       = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_FILL;
         idx_q   <= '0;
      end else if (wr_fire || rd_fire) begin
         if (idx_q == IDX_LAST) begin
            idx_q   <= '0;
            phase_q <= (phase_q == PH_FILL) ? PH_DRAIN : PH_FILL;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tile_store.sv
module tile_store #(
   parameter int N = 8,
   localparam int IW = $clog2(N)
) (
   input  logic           clk,
   input  logic           wr_en,
   input  logic [IW-1:0]  wr_row,
   input  logic [N-1:0]   wr_data,
   output logic [N*N-1:0] rows_flat
);
   for (genvar r = 0; r < N; r++) begin : g_row
      logic [N-1:0] row_q;
      always_ff @(posedge clk) begin
         if (wr_en && (wr_row == IW'(r))) row_q <= wr_data;
      end
      assign rows_flat[r*N +: N] = row_q;
   end
endmodule

// File: rtl/bit_transpose.sv
module bit_transpose #(
   parameter int N = 8,
   localparam int IW = $clog2(N)
) (
   input  logic [N*N-1:0] rows_flat,
   input  logic [IW-1:0]  col_sel,
   output logic [N-1:0]   col_byte
);
   logic [IW-1:0] bit_pos;
   assign bit_pos = IW'(N - 1) - col_sel;

   for (genvar r = 0; r < N; r++) begin : g_tap
      logic [N-1:0] row_w;
      assign row_w       = rows_flat[r*N +: N];
      assign col_byte[r] = row_w[bit_pos];
   end
endmodule

// File: rtl/tile_walker.sv
module tile_walker #(
   parameter int TX = 16,
   parameter int TY = 8,
   localparam int XW = $clog2(TX),
   localparam int YW = $clog2(TY)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tile_end,
   output logic [XW-1:0] tile_x,
   output logic [YW-1:0] tile_y,
   output logic          frame_done
);
   localparam logic [XW-1:0] X_LAST = XW'(TX - 1);
   localparam logic [YW-1:0] Y_LAST = YW'(TY - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tile_x     <= '0;
         tile_y     <= '0;
         frame_done <= 1'b0;
      end else begin
         frame_done <= tile_end && (tile_x == X_LAST) && (tile_y == Y_LAST);
         if (tile_end) begin
            if (tile_x == X_LAST) begin
               tile_x <= '0;
               tile_y <= (tile_y == Y_LAST) ? '0 : tile_y + 1'b1;
            end else begin
               tile_x <= tile_x + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pix_tile_rotator.sv
module pix_tile_rotator #(
   parameter int TILE_N  = 8,
   parameter int FRAME_W = 128,
   parameter int FRAME_H = 64,
   localparam int IW = $clog2(TILE_N),
   localparam int TX = FRAME_W / TILE_N,
   localparam int TY = FRAME_H / TILE_N,
   localparam int XW = $clog2(TX),
   localparam int YW = $clog2(TY)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [TILE_N-1:0] in_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [TILE_N-1:0] out_data,
   output logic [IW-1:0]     out_col,
   output logic [XW-1:0]     out_tile_x,
   output logic [YW-1:0]     out_tile_y,
   output logic              frame_done
);
   if (TILE_N < 2 || (1 << IW) != TILE_N) begin : g_bad_tile
      $error("TILE_N must be a power of two of at least 2");
   end
   if (FRAME_W % TILE_N != 0 || FRAME_H % TILE_N != 0) begin : g_bad_frame
      $error("frame size must be a whole number of tiles");
   end
   if (TX < 2 || TY < 2 || (1 << XW) != TX || (1 << YW) != TY) begin : g_bad_grid
      $error("tile grid must be a power of two of at least 2 each way");
   end

   logic                     wr_fire;
   logic                     tile_end;
   logic [IW-1:0]            idx;
   logic [TILE_N*TILE_N-1:0] rows_flat;

   tile_phase_ctrl #(.N(TILE_N)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .out_ready (out_ready),
      .in_ready  (in_ready),
      .out_valid (out_valid),
      .wr_fire   (wr_fire),
      .tile_end  (tile_end),
      .idx       (idx)
   );

   tile_store #(.N(TILE_N)) u_store (
      .clk       (clk),
      .wr_en     (wr_fire),
      .wr_row    (idx),
      .wr_data   (in_data),
      .rows_flat (rows_flat)
   );

   bit_transpose #(.N(TILE_N)) u_xpose (
      .rows_flat (rows_flat),
      .col_sel   (idx),
      .col_byte  (out_data)
   );

   tile_walker #(.TX(TX), .TY(TY)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .tile_end   (tile_end),
      .tile_x     (out_tile_x),
      .tile_y     (out_tile_y),
      .frame_done (frame_done)
   );

   assign out_col = idx;
endmodule

// File: rtl/pix_tile_rotator_chk.sv
module pix_tile_rotator_chk #(
   parameter int N  = 8,
   parameter int XW = 4,
   parameter int YW = 3,
   localparam int IW = $clog2(N)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic [N-1:0]  in_data,
   input logic          out_valid,
   input logic          out_ready,
   input logic [N-1:0]  out_data,
   input logic [IW-1:0] out_col,
   input logic [XW-1:0] out_tile_x,
   input logic [YW-1:0] out_tile_y,
   input logic          frame_done
);
   localparam logic [IW-1:0] C_LAST = IW'(N - 1);
   localparam logic [XW-1:0] X_LAST = '1;
   localparam logic [YW-1:0] Y_LAST = '1;

   logic col_hs_last;
   assign col_hs_last = out_valid && out_ready && (out_col == C_LAST);

   AST_RESET_IDLE: assert property (@(posedge clk)
      $rose(rst_n) |-> in_ready && !out_valid && !frame_done) else $error("reset state"); // R1
   AST_NO_FILL_DURING_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready) else $error("input open during drain"); // R2
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_col)) else $error("output not held"); // R5
   AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && (out_col != C_LAST) |=> out_valid && (out_col == IW'($past(out_col) + 1'b1))) else $error("column order"); // R7
   AST_TILE_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      col_hs_last && (out_tile_x != X_LAST) |=> (out_tile_x == XW'($past(out_tile_x) + 1'b1)) && $stable(out_tile_y)) else $error("tile step"); // R8
   AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(col_hs_last && (out_tile_x == X_LAST) && (out_tile_y == Y_LAST))) else $error("stray frame_done"); // R9
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done) else $error("frame_done too long"); // R9
endmodule

bind pix_tile_rotator pix_tile_rotator_chk #(.N(TILE_N), .XW(XW), .YW(YW)) u_chk (.*);

// File: tb/pix_tile_rotator_bench.sv
`timescale 1ns/1ps
module pix_tile_rotator_bench;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       in_valid;
   logic       in_ready;
   logic [7:0] in_data;
   logic       out_valid;
   logic       out_ready;
   logic [7:0] out_data;
   logic [2:0] out_col;
   logic [3:0] out_tile_x;
   logic [2:0] out_tile_y;
   logic       frame_done;

   always #10 clk = ~clk;

   pix_tile_rotator u_pix_tile_rotator (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_col(out_col), .out_tile_x(out_tile_x), .out_tile_y(out_tile_y),
      .frame_done(frame_done)
   );

   int errors = 0;
   int checks = 0;
   logic [7:0] rows [8];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // R4: column k bit r = row r bit (7-k)
   function automatic logic [7:0] col_ref(input int k);
      logic [7:0] b;
      for (int r = 0; r < 8; r++) b[r] = rows[r][7-k];
      return b;
   endfunction

   function automatic logic [7:0] row_gen(input int t, input int r);
      case (t)
         0: return 8'h80 >> r;
         1: return (r == 0) ? 8'h80 : 8'h00;
         2: return 8'hFF;
         3: return (r == 7) ? 8'h01 : 8'h00;
         4: return (r % 2 == 0) ? 8'hAA : 8'h55;
         default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      int   wr, col, tx, ty, tile_no, cyc;
      bit   drain, done_exp, hold_prev;
      logic [7:0] prev_data;
      int   seed_v;
      seed_v = $urandom(32'd1357);
      rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
      wr = 0; col = 0; tx = 0; ty = 0; tile_no = 0; cyc = 0;
      drain = 0; done_exp = 0; hold_prev = 0; prev_data = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(in_ready == 1'b1, "R1", in_ready, 1);
      chk(out_valid == 1'b0, "R1", out_valid, 0);
      chk(frame_done == 1'b0, "R1", frame_done, 0);
      chk(out_tile_x == 0 && out_tile_y == 0, "R1", {out_tile_y, out_tile_x}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      while (tile_no < 132) begin
         chk(in_ready == !drain, "R2", in_ready, !drain);
         chk(out_valid == drain, "R3", out_valid, drain);
         if (drain) begin
            chk(out_data == col_ref(col), "R4", out_data, col_ref(col));
            chk(out_col == 3'(col), "R7", out_col, col);
            chk(out_tile_x == 4'(tx) && out_tile_y == 3'(ty), "R8",
                {out_tile_y, out_tile_x}, {ty[2:0], tx[3:0]});
         end
         if (hold_prev) chk(out_data == prev_data, "R5", out_data, prev_data);
         chk(frame_done == done_exp, "R9", frame_done, done_exp);

         in_valid  = ($urandom % 10) < 7;
         out_ready = (tile_no % 7 == 5) ? (($urandom % 10) < 2) : (($urandom % 10) < 6);
         if (!drain && in_valid) in_data = row_gen(tile_no, wr);
         else in_data = 8'($urandom);   // R6: garbage while stalled

         done_exp  = 0;
         hold_prev = drain && !out_ready;
         prev_data = out_data;
         if (!drain && in_valid) begin
            rows[wr] = in_data;
            wr++;
            if (wr == 8) begin drain = 1; wr = 0; col = 0; end
         end else if (drain && out_ready) begin
            col++;
            if (col == 8) begin
               drain = 0;
               if (tx == 15 && ty == 7) done_exp = 1;
               if (tx == 15) begin tx = 0; ty = (ty + 1) % 8; end
               else tx++;
               tile_no++;
            end
         end
         @(negedge clk);
         cyc++;
         if (cyc > 20000) begin
            chk(1'b0, "watchdog", cyc, 20000);
            break;
         end
      end
      chk(frame_done == done_exp, "R9", frame_done, done_exp);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule